// File: doc/BRIEF.md
# Receive Buffer Ring Fetcher

This block walks a circular table of receive buffer entries held in system memory. Each entry is four 16-bit words. Together they give a 32-bit buffer address and a 32-bit remaining word count. When a fetch is started, the block reads the four words of the entry under the read pointer. Each word is one request/acknowledge transaction on a simple memory read port. The words are loaded into the current buffer address and remaining count outputs. The read pointer then moves past the entry, wrapping to the start pointer when it lands on the end pointer.

The host programs four 16-bit offsets: start, end, read and write. It also supplies the upper 16 address bits and selects 16-bit or 32-bit memory mode. When the read pointer reaches the host's write pointer, an exhaustion flag is raised. Clearing that flag launches another fetch.

The receive path signals when the current buffer is used up. If no further entry is available, reception is blocked until a fetch succeeds. Otherwise the next entry is fetched at once.

Top module: `rbr_ring_mgr`

## Requirements
- R1: A pointer register write (select 0 start, 1 end, 2 read, 3 write) stores the data with bit 0 forced to 0 in 16-bit mode (`wide_mode`=0), and with bits [1:0] forced to 0 in 32-bit mode (`wide_mode`=1). The stored value reads back on `cfg_rdata` for the selected register.
- R2: A fetch issues exactly four memory reads, one per `mem_req`/`mem_ack` handshake, at addresses {`upper_addr`, read pointer + k*S} for k = 0..3. S is 2 in 16-bit mode and 4 in 32-bit mode. `mem_req` and `mem_addr` hold steady until acknowledged.
- R3: After a fetch, `buf_addr` = {word1, word0} and `word_count` = {word3, word2}, where word k is the data returned for read k.
- R4: After a fetch, the read pointer has advanced by 8 bytes in 16-bit mode and by 16 bytes in 32-bit mode.
- R5: If the advanced read pointer equals the end pointer, the read pointer is reloaded with the start pointer.
- R6: If the read pointer after any wrap equals the write pointer, `exh_flag` is set.
- R7: `exh_clr` while `exh_flag` is set clears the flag and starts a fetch. `exh_clr` while the flag is clear has no effect: no fetch runs and the read pointer is unchanged.
- R8: `last_buf` while the read pointer equals the write pointer sets `rx_block` and starts no fetch. The next completed fetch clears `rx_block`.
- R9: `last_buf` while the read pointer differs from the write pointer starts a fetch.
- R10: A fetch trigger that arrives during a fetch is held pending. A second fetch then runs from the updated read pointer.
- R11: `busy` is high from the first memory request of a fetch through its register update cycle, and `mem_req` is never high while `busy` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wide_mode | input | 1 | 1 = 32-bit memory mode, 0 = 16-bit mode |
| upper_addr | input | 16 | Upper address bits for entry reads |
| cfg_we | input | 1 | Pointer register write strobe |
| cfg_sel | input | 2 | Pointer select (0 start, 1 end, 2 read, 3 write) for write and readback |
| cfg_wdata | input | 16 | Pointer write data |
| cfg_rdata | output | 16 | Selected pointer value |
| fetch_cmd | input | 1 | Read-resource command pulse |
| exh_clr | input | 1 | Host clear of the exhaustion flag |
| last_buf | input | 1 | Receive path reports the current buffer is used up |
| mem_req | output | 1 | Memory read request |
| mem_addr | output | 32 | Memory read byte address |
| mem_ack | input | 1 | Memory read acknowledge, data valid |
| mem_rdata | input | 16 | Memory read data |
| busy | output | 1 | Fetch in progress |
| buf_addr | output | 32 | Current receive buffer address |
| word_count | output | 32 | Remaining word count of current buffer |
| exh_flag | output | 1 | Buffer ring exhausted |
| rx_block | output | 1 | Reception blocked, no buffer available |

## Verification
A wrong word index or a wrong step appears at once on `mem_addr`, during the same fetch. A mis-wired word load shows on `buf_addr` or `word_count` as soon as `busy` falls. A wrong advance or wrap of the read pointer shows on the readback, and on the first address of the following fetch. A missed comparison against the write pointer leaves `exh_flag` or `rx_block` wrong in the cycle after the update. A lost pending trigger appears as one advance instead of two.

// File: rtl/rbr_pkg.sv
// Shared types for the receive buffer ring fetcher.
// Assumes 16-bit pointer offsets and four-word ring entries.
package rbr_pkg;
    localparam int ENTRY_WORDS = 4;

    typedef enum logic [1:0] {
        PSEL_START = 2'd0,
        PSEL_END   = 2'd1,
        PSEL_RD    = 2'd2,
        PSEL_WR    = 2'd3
    } ptr_sel_e;

    typedef enum logic [1:0] {
        FS_IDLE   = 2'd0,
        FS_READ   = 2'd1,
        FS_UPDATE = 2'd2
    } fetch_state_e;
endpackage

// File: rtl/rbr_ptr_bank.sv
// Pointer register bank: start, end, read and write offsets.
// Host writes are aligned to the memory mode.
// A fetch update of the read pointer wins over a host write in the same cycle.
module rbr_ptr_bank #(
    parameter int PTR_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wide_mode,
    input  logic             wr_en,
    input  logic [1:0]       wr_sel,
    input  logic [PTR_W-1:0] wr_data,
    input  logic             upd_en,
    input  logic [PTR_W-1:0] upd_rd,
    output logic [PTR_W-1:0] start_ptr,
    output logic [PTR_W-1:0] end_ptr,
    output logic [PTR_W-1:0] rd_ptr,
    output logic [PTR_W-1:0] wr_ptr
);
    import rbr_pkg::*;

    localparam int NUM_PTRS = 4;

    logic [NUM_PTRS-1:0][PTR_W-1:0] ptr_q;
    logic [PTR_W-1:0]               wr_masked;

    // Align written data: clear bit 0 (16-bit) or bits [1:0] (32-bit)
    always_comb begin
        wr_masked = wr_data & ~(wide_mode ? PTR_W'(3) : PTR_W'(1));
    end

    for (genvar g = 0; g < NUM_PTRS; g++) begin : g_ptr
        logic [PTR_W-1:0] q;
        // Hold one pointer, with fetch update priority on the read pointer
        always_ff @(posedge clk) begin
            if (!rst_n)
                q <= '0;
            else if (upd_en && (2'(g) == PSEL_RD))
                q <= upd_rd;
            else if (wr_en && (wr_sel == 2'(g)))
                q <= wr_masked;
        end
        assign ptr_q[g] = q;
    end

    assign start_ptr = ptr_q[PSEL_START];
    assign end_ptr   = ptr_q[PSEL_END];
    assign rd_ptr    = ptr_q[PSEL_RD];
    assign wr_ptr    = ptr_q[PSEL_WR];
endmodule

// File: rtl/rbr_fetch_engine.sv
// Fetch sequencer: reads one four-word ring entry via req/ack.
// It loads the buffer address and word count, then computes the next read pointer with wrap.
// Assumes mem_rdata is valid in the cycle mem_ack is high, and that wide_mode is stable while busy.
module rbr_fetch_engine #(
    parameter int PTR_W  = 16,
    parameter int DATA_W = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wide_mode,
    input  logic [DATA_W-1:0]   upper_addr,
    input  logic [PTR_W-1:0]    start_ptr,
    input  logic [PTR_W-1:0]    end_ptr,
    input  logic [PTR_W-1:0]    rd_ptr,
    input  logic                trigger,
    output logic                mem_req,
    output logic [DATA_W+PTR_W-1:0] mem_addr,
    input  logic                mem_ack,
    input  logic [DATA_W-1:0]   mem_rdata,
    output logic                busy,
    output logic                upd_en,
    output logic [PTR_W-1:0]    upd_rd,
    output logic [2*DATA_W-1:0] buf_addr,
    output logic [2*DATA_W-1:0] word_count
);
    import rbr_pkg::*;

    localparam int IDX_W = $clog2(ENTRY_WORDS);

    fetch_state_e     state;
    logic [IDX_W-1:0] idx;
    logic             pend;
    logic [PTR_W-1:0] word_off;
    logic [PTR_W-1:0] adv_ptr;

    // Byte offset of the current word and the advanced pointer for this mode
    always_comb begin
        word_off = wide_mode ? (PTR_W'(idx) << 2) : (PTR_W'(idx) << 1);
        adv_ptr  = rd_ptr + (wide_mode ? PTR_W'(ENTRY_WORDS * 4) : PTR_W'(ENTRY_WORDS * 2));
        upd_rd   = (adv_ptr == end_ptr) ? start_ptr : adv_ptr;
    end

    assign mem_req  = (state == FS_READ);
    assign mem_addr = {upper_addr, rd_ptr + word_off};
    assign busy     = (state != FS_IDLE);
    assign upd_en   = (state == FS_UPDATE);

    // Sequence the four word reads and the pointer update; queue one extra trigger
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= FS_IDLE;
            idx   <= '0;
            pend  <= 1'b0;
        end else begin
            case (state)
                FS_IDLE: begin
                    if (trigger) begin
                        state <= FS_READ;
                        idx   <= '0;
                    end
                end
                FS_READ: begin
                    if (trigger) pend <= 1'b1;
                    if (mem_ack) begin
                        if (idx == IDX_W'(ENTRY_WORDS - 1)) state <= FS_UPDATE;
                        else                                 idx   <= idx + 1'b1;
                    end
                end
                FS_UPDATE: begin
                    idx  <= '0;
                    pend <= 1'b0;
                    state <= (pend || trigger) ? FS_READ : FS_IDLE;
                end
                default: state <= FS_IDLE;
            endcase
        end
    end

    // Capture each returned word into its half of the address or count
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            buf_addr   <= '0;
            word_count <= '0;
        end else if (mem_req && mem_ack) begin
            case (idx)
                2'd0: buf_addr[DATA_W-1:0]          <= mem_rdata;
                2'd1: buf_addr[2*DATA_W-1:DATA_W]   <= mem_rdata;
                2'd2: word_count[DATA_W-1:0]        <= mem_rdata;
                default: word_count[2*DATA_W-1:DATA_W] <= mem_rdata;
            endcase
        end
    end
endmodule

// File: rtl/rbr_ring_mgr.sv
// Top of the receive buffer ring fetcher.
// Combines fetch triggers (command, exhaustion clear, buffer used up), keeps the
// exhaustion flag and the reception block, and joins pointer bank and fetch engine.
// Assumes single-cycle pulses on fetch_cmd, exh_clr and last_buf.
module rbr_ring_mgr #(
    parameter int PTR_W  = 16,
    parameter int DATA_W = 16
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      wide_mode,
    input  logic [DATA_W-1:0]         upper_addr,
    input  logic                      cfg_we,
    input  logic [1:0]                cfg_sel,
    input  logic [PTR_W-1:0]          cfg_wdata,
    output logic [PTR_W-1:0]          cfg_rdata,
    input  logic                      fetch_cmd,
    input  logic                      exh_clr,
    input  logic                      last_buf,
    output logic                      mem_req,
    output logic [DATA_W+PTR_W-1:0]   mem_addr,
    input  logic                      mem_ack,
    input  logic [DATA_W-1:0]         mem_rdata,
    output logic                      busy,
    output logic [2*DATA_W-1:0]       buf_addr,
    output logic [2*DATA_W-1:0]       word_count,
    output logic                      exh_flag,
    output logic                      rx_block
);
    import rbr_pkg::*;

    logic [PTR_W-1:0] start_ptr, end_ptr, rd_ptr, wr_ptr, upd_rd;
    logic             upd_en, trigger, ring_empty;

    rbr_ptr_bank #(.PTR_W(PTR_W)) u_ptrs (
        .clk(clk), .rst_n(rst_n), .wide_mode(wide_mode),
        .wr_en(cfg_we), .wr_sel(cfg_sel), .wr_data(cfg_wdata),
        .upd_en(upd_en), .upd_rd(upd_rd),
        .start_ptr(start_ptr), .end_ptr(end_ptr), .rd_ptr(rd_ptr), .wr_ptr(wr_ptr)
    );

    rbr_fetch_engine #(.PTR_W(PTR_W), .DATA_W(DATA_W)) u_fetch (
        .clk(clk), .rst_n(rst_n), .wide_mode(wide_mode), .upper_addr(upper_addr),
        .start_ptr(start_ptr), .end_ptr(end_ptr), .rd_ptr(rd_ptr), .trigger(trigger),
        .mem_req(mem_req), .mem_addr(mem_addr), .mem_ack(mem_ack), .mem_rdata(mem_rdata),
        .busy(busy), .upd_en(upd_en), .upd_rd(upd_rd),
        .buf_addr(buf_addr), .word_count(word_count)
    );

    // Readback mux of the selected pointer
    always_comb begin
        case (cfg_sel)
            PSEL_START: cfg_rdata = start_ptr;
            PSEL_END:   cfg_rdata = end_ptr;
            PSEL_RD:    cfg_rdata = rd_ptr;
            default:    cfg_rdata = wr_ptr;
        endcase
    end

    // Combine the three fetch sources
    always_comb begin
        ring_empty = (rd_ptr == wr_ptr);
        trigger    = fetch_cmd | (exh_clr & exh_flag) | (last_buf & ~ring_empty);
    end

    // Exhaustion flag: set by an update landing on the write pointer, cleared by host
    always_ff @(posedge clk) begin
        if (!rst_n)                          exh_flag <= 1'b0;
        else if (upd_en && upd_rd == wr_ptr) exh_flag <= 1'b1;
        else if (exh_clr)                    exh_flag <= 1'b0;
    end

    // Reception block: set when the last buffer is used with no entry left, cleared by a fetch
    always_ff @(posedge clk) begin
        if (!rst_n)                       rx_block <= 1'b0;
        else if (upd_en)                  rx_block <= 1'b0;
        else if (last_buf && ring_empty)  rx_block <= 1'b1;
    end
endmodule

// File: rtl/rbr_ring_mgr_chk.sv
// Protocol and status checker for rbr_ring_mgr, attached by bind.
module rbr_ring_mgr_chk #(
    parameter int PTR_W  = 16,
    parameter int DATA_W = 16
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic                    mem_req,
    input logic                    mem_ack,
    input logic [DATA_W+PTR_W-1:0] mem_addr,
    input logic [DATA_W-1:0]       upper_addr,
    input logic                    busy,
    input logic                    last_buf,
    input logic                    rx_block,
    input logic                    exh_flag
);
    // R11
    req_inside_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> busy);

    // R2
    req_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr)));

    // R2
    req_upper_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> (mem_addr[DATA_W+PTR_W-1:PTR_W] == upper_addr));

    // R8
    block_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rx_block) |-> $past(last_buf));

    // R6
    exh_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(exh_flag) |-> $past(busy));
endmodule

bind rbr_ring_mgr rbr_ring_mgr_chk #(.PTR_W(PTR_W), .DATA_W(DATA_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .mem_req(mem_req), .mem_ack(mem_ack),
    .mem_addr(mem_addr), .upper_addr(upper_addr), .busy(busy),
    .last_buf(last_buf), .rx_block(rx_block), .exh_flag(exh_flag)
);

// File: tb/rbr_ring_mgr_bench.sv
// Directed bench for rbr_ring_mgr with a req/ack memory model.
module rbr_ring_mgr_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wide_mode = 1'b0;
    logic [15:0] upper_addr = 16'h0012;
    logic        cfg_we = 1'b0;
    logic [1:0]  cfg_sel = 2'd0;
    logic [15:0] cfg_wdata = '0;
    logic [15:0] cfg_rdata;
    logic        fetch_cmd = 1'b0, exh_clr = 1'b0, last_buf = 1'b0;
    logic        mem_req, mem_ack = 1'b0;
    logic [31:0] mem_addr;
    logic [15:0] mem_rdata = '0;
    logic        busy, exh_flag, rx_block;
    logic [31:0] buf_addr, word_count;

    int checks = 0, fails = 0, acks = 0;

    always #4 clk = ~clk;

    rbr_ring_mgr u_rbr_ring_mgr (
        .clk(clk), .rst_n(rst_n), .wide_mode(wide_mode), .upper_addr(upper_addr),
        .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
        .fetch_cmd(fetch_cmd), .exh_clr(exh_clr), .last_buf(last_buf),
        .mem_req(mem_req), .mem_addr(mem_addr), .mem_ack(mem_ack), .mem_rdata(mem_rdata),
        .busy(busy), .buf_addr(buf_addr), .word_count(word_count),
        .exh_flag(exh_flag), .rx_block(rx_block)
    );

    function automatic logic [15:0] memf(input logic [31:0] a);
        return a[15:0] ^ a[31:16] ^ 16'h3C5A;
    endfunction

    // Memory model: acknowledge each request for one cycle, counting words
    initial begin
        forever begin
            @(negedge clk);
            if (mem_ack) mem_ack = 1'b0;
            else if (mem_req) begin
                mem_ack   = 1'b1;
                mem_rdata = memf(mem_addr);
                acks++;
            end
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr_ptr_reg(input logic [1:0] sel, input logic [15:0] d);
        @(negedge clk); cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = d;
        @(negedge clk); cfg_we = 1'b0;
    endtask

    task automatic rd_ptr_reg(input logic [1:0] sel, output logic [15:0] d);
        cfg_sel = sel; #1; d = cfg_rdata;
    endtask

    task automatic pulse(input int which);
        @(negedge clk);
        case (which)
            0: fetch_cmd = 1'b1;
            1: exh_clr   = 1'b1;
            default: last_buf = 1'b1;
        endcase
        @(negedge clk);
        fetch_cmd = 1'b0; exh_clr = 1'b0; last_buf = 1'b0;
    endtask

    task automatic wait_idle();
        for (int i = 0; i < 200 && busy; i++) @(negedge clk);
    endtask

    task automatic chk_entry(input string req, input logic [15:0] base, input int step);
        logic [31:0] b = {upper_addr, base};
        chk(req, buf_addr, {memf(b + step), memf(b)});
        chk(req, word_count, {memf(b + 3*step), memf(b + 2*step)});
    endtask

    task automatic t_reset();
        logic [15:0] v;
        chk("R11 reset busy", 32'(busy), 0);
        chk("R11 reset mem_req", 32'(mem_req), 0);
        chk("R6 reset exh_flag", 32'(exh_flag), 0);
        chk("R8 reset rx_block", 32'(rx_block), 0);
        rd_ptr_reg(2'd2, v); chk("R1 reset read pointer", 32'(v), 0);
    endtask

    task automatic t_mask16();
        logic [15:0] v;
        wr_ptr_reg(2'd0, 16'h0101); wr_ptr_reg(2'd1, 16'h0121);
        wr_ptr_reg(2'd2, 16'h0100); wr_ptr_reg(2'd3, 16'h0119);
        rd_ptr_reg(2'd0, v); chk("R1 start 16-bit mask", 32'(v), 32'h0100);
        rd_ptr_reg(2'd1, v); chk("R1 end 16-bit mask", 32'(v), 32'h0120);
        rd_ptr_reg(2'd3, v); chk("R1 write 16-bit mask", 32'(v), 32'h0118);
    endtask

    task automatic t_fetch16();
        logic [15:0] v;
        int a0 = acks;
        pulse(0);
        chk("R11 busy during fetch", 32'(busy), 1);
        wait_idle();
        chk("R2 four reads", 32'(acks - a0), 4);
        chk_entry("R3 16-bit entry", 16'h0100, 2);
        rd_ptr_reg(2'd2, v); chk("R4 advance 8", 32'(v), 32'h0108);
        chk("R6 no exhaustion", 32'(exh_flag), 0);
    endtask

    task automatic t_pending();
        logic [15:0] v;
        int a0 = acks;
        pulse(0);
        repeat (2) @(negedge clk);
        pulse(0);
        wait_idle();
        chk("R10 two fetches", 32'(acks - a0), 8);
        chk_entry("R10 second entry", 16'h0110, 2);
        rd_ptr_reg(2'd2, v); chk("R10 advanced twice", 32'(v), 32'h0118);
        chk("R6 exhaustion on meet", 32'(exh_flag), 1);
    endtask

    task automatic t_block();
        int a0 = acks;
        pulse(2);
        repeat (3) @(negedge clk);
        chk("R8 block set", 32'(rx_block), 1);
        chk("R8 no fetch", 32'(acks - a0), 0);
    endtask

    task automatic t_exh_clear();
        logic [15:0] v;
        pulse(1);
        chk("R7 flag cleared", 32'(exh_flag), 0);
        chk("R7 fetch started", 32'(busy), 1);
        wait_idle();
        chk_entry("R7 fetched entry", 16'h0118, 2);
        rd_ptr_reg(2'd2, v); chk("R5 wrap to start", 32'(v), 32'h0100);
        chk("R8 block cleared by fetch", 32'(rx_block), 0);
        chk("R6 flag stays clear", 32'(exh_flag), 0);
    endtask

    task automatic t_last_fetch();
        logic [15:0] v;
        pulse(2);
        chk("R9 fetch started", 32'(busy), 1);
        wait_idle();
        rd_ptr_reg(2'd2, v); chk("R9 pointer advanced", 32'(v), 32'h0108);
        chk("R9 no block", 32'(rx_block), 0);
    endtask

    task automatic t_clr_noop();
        logic [15:0] v;
        int a0 = acks;
        pulse(1);
        repeat (3) @(negedge clk);
        chk("R7 clear ignored, no fetch", 32'(acks - a0) | 32'(busy), 0);
        rd_ptr_reg(2'd2, v); chk("R7 pointer kept", 32'(v), 32'h0108);
    endtask

    task automatic t_wide();
        logic [15:0] v;
        @(negedge clk); wide_mode = 1'b1; upper_addr = 16'h0A40;
        wr_ptr_reg(2'd0, 16'h0203); wr_ptr_reg(2'd1, 16'h0222);
        wr_ptr_reg(2'd2, 16'h0211); wr_ptr_reg(2'd3, 16'h0201);
        rd_ptr_reg(2'd0, v); chk("R1 start 32-bit mask", 32'(v), 32'h0200);
        rd_ptr_reg(2'd2, v); chk("R1 read 32-bit mask", 32'(v), 32'h0210);
        pulse(0);
        wait_idle();
        chk_entry("R2 32-bit spacing", 16'h0210, 4);
        rd_ptr_reg(2'd2, v); chk("R5 wrap after 16-byte advance", 32'(v), 32'h0200);
        chk("R6 exhaustion after wrap", 32'(exh_flag), 1);
    endtask

    task automatic t_wide_adv();
        logic [15:0] v;
        wr_ptr_reg(2'd1, 16'h0300);
        pulse(1);
        wait_idle();
        rd_ptr_reg(2'd2, v); chk("R4 advance 16", 32'(v), 32'h0210);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual running expected finished");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_mask16();
        t_fetch16();
        t_pending();
        t_block();
        t_exh_clear();
        t_last_fetch();
        t_clr_noop();
        t_wide();
        t_wide_adv();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end
endmodule